// File: doc/BRIEF.md
# Oscillator Settle Gate with Per-Output Clock Source Selection

After reset this block keeps every internal clock output at zero. It waits for a fixed number of cycles of the main oscillator, so that the crystal has time to reach stable oscillation. When that count is done it sets a sticky ready flag. The flag is brought into the oscillator, PLL and sub-oscillator domains through two-flop synchronizers. Each source is passed through to the outputs only after its own synchronized copy of the flag is high.

Each output draws its source from a 2-bit mode field, written through a simple write port that is clocked by the oscillator:

- The main clock may come from the oscillator or the PLL.
- The peripheral clock may follow the main clock or take the slow sub-oscillator.
- Each auxiliary clock picks freely among the three sources.

Selection is a gated AND-OR choice; it is not an analog glitch-free switch. Mode writes made while the oscillator is settling are stored and come into force once the ready flag is set.

Top module: `clk_settle_sel`

## Requirements
- R1: From reset release until the ready flag sets, every clock output is held at 0. `ready_o` rises on the 2^SETTLE_LOG2-th rising edge of `osc_clk_i` after reset release (default 2^18, about 16.4 ms at 16 MHz).
- R2: Once set, `ready_o` stays high until reset. The settle counter saturates at 2^SETTLE_LOG2.
- R3: Each source is passed only after the ready flag has gone through two flops in that source's domain. An output fed from the oscillator first follows `osc_clk_i` from the second oscillator rising edge after the edge that set `ready_o`.
- R4: Field 0 selects the main clock. Code 01 selects the PLL. Codes 00, 10 and 11 select the oscillator.
- R5: Field 1 selects the peripheral clock. Code 10 selects the sub-oscillator. Any other code makes it follow the main clock output.
- R6: Fields 2 to N_AUX+1 select auxiliary clocks 0 to N_AUX-1. Code 00 selects the oscillator, 01 the PLL and 10 the sub-oscillator. Code 11 is reserved and selects the oscillator.
- R7: Mode writes made before `ready_o` sets are kept, and they take effect once it is set. A write whose index is N_AUX+2 or higher changes no field.
- R8: With `ready_o` set, a mode captured on one oscillator rising edge takes effect at the next oscillator rising edge.
- R9: Asserting `rst_ni` low at once clears the ready flag, the counter and all mode fields to 00, and drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Main crystal oscillator clock; also clocks the counter and the mode registers |
| pll_clk_i | input | 1 | PLL output clock |
| sub_clk_i | input | 1 | Slow sub-oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Mode write strobe, sampled on `osc_clk_i` |
| wr_idx_i | input | $clog2(N_AUX+2) | Index of the mode field to write |
| wr_mode_i | input | 2 | Mode code to write |
| ready_o | output | 1 | Sticky settle-done flag in the oscillator domain |
| main_clk_o | output | 1 | Gated main clock |
| periph_clk_o | output | 1 | Gated peripheral clock |
| aux_clk_o | output | N_AUX | Gated auxiliary clocks |

## Verification
The hardest case to reach is a mode write that lands while the counter is still running. That write cannot be seen at the outputs, and it has to show up only after the ready flag sets. The bench issues its writes in the first few oscillator cycles after reset release and holds a long window to confirm that all outputs stay at zero. It then checks the edge on which the flag rises and the edge on which the oscillator is first passed through. Only after that does it compare every output against its source. To make the short count reachable, the bench shrinks the settle length to 2^5 through the parameter. It also repeats a reset in the middle of operation to show that the stored modes return to 00.

// File: rtl/clk_settle_pkg.sv
package clk_settle_pkg;

  typedef enum logic [1:0] {SRC_OSC = 2'd0, SRC_PLL = 2'd1, SRC_SUB = 2'd2} src_e;

  // Main clock: only code 01 reaches the PLL
  function automatic logic main_takes_pll(input logic [1:0] m);
    return m == 2'b01;
  endfunction

  // Peripheral clock: only code 10 reaches the sub-oscillator
  function automatic logic periph_takes_sub(input logic [1:0] m);
    return m == 2'b10;
  endfunction

  // Auxiliary clocks: reserved code 11 falls back to the oscillator
  function automatic src_e aux_source(input logic [1:0] m);
    case (m)
      2'b01:   return SRC_PLL;
      2'b10:   return SRC_SUB;
      default: return SRC_OSC;
    endcase
  endfunction

  function automatic logic pick_gated(input src_e s, input logic g_osc,
                                      input logic g_pll, input logic g_sub);
    case (s)
      SRC_PLL: return g_pll;
      SRC_SUB: return g_sub;
      default: return g_osc;
    endcase
  endfunction

  function automatic logic settle_last(input int unsigned cnt, input int unsigned tc);
    return cnt == tc - 1;
  endfunction

endpackage

// File: rtl/clk_sync2.sv
module clk_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      q    <= 1'b0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/clk_settle_cnt.sv
module clk_settle_cnt #(
  parameter int LOG2 = 18,
  localparam int CW = LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          ready_o,
  output logic [CW-1:0] cnt_o
);
  import clk_settle_pkg::*;

  localparam int unsigned TC = 32'd1 << LOG2;
  localparam logic [CW-1:0] TC_V = CW'(TC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o   <= '0;
      ready_o <= 1'b0;
    end else if (cnt_o != TC_V) begin
      cnt_o <= cnt_o + 1'b1;
      if (settle_last(32'(cnt_o), TC)) ready_o <= 1'b1;
    end
  end
endmodule

// File: rtl/clk_mode_regs.sv
module clk_mode_regs #(
  parameter int NF = 5,
  parameter int IW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ready,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [1:0]      wr_mode,
  output logic [NF*2-1:0] shadow_o,
  output logic [NF*2-1:0] active_o
);
  for (genvar f = 0; f < NF; f++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_o[f*2 +: 2] <= 2'b00;
        active_o[f*2 +: 2] <= 2'b00;
      end else begin
        if (wr_en && wr_idx == IW'(f)) shadow_o[f*2 +: 2] <= wr_mode;
        if (ready) active_o[f*2 +: 2] <= shadow_o[f*2 +: 2];
      end
    end
  end
endmodule

// File: rtl/clk_settle_sel.sv
module clk_settle_sel #(
  parameter int SETTLE_LOG2 = 18,
  parameter int N_AUX = 3,
  localparam int NF = N_AUX + 2,
  localparam int IW = $clog2(NF)
) (
  input  logic             osc_clk_i,
  input  logic             pll_clk_i,
  input  logic             sub_clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [1:0]       wr_mode_i,
  output logic             ready_o,
  output logic             main_clk_o,
  output logic             periph_clk_o,
  output logic [N_AUX-1:0] aux_clk_o
);
  import clk_settle_pkg::*;

  logic [SETTLE_LOG2:0] settle_cnt;
  logic [NF*2-1:0]      mode_shadow;
  logic [NF*2-1:0]      mode_active;
  logic                 en_osc, en_pll, en_sub;
  logic                 gate_osc, gate_pll, gate_sub;

  clk_settle_cnt #(.LOG2(SETTLE_LOG2)) u_cnt (
    .clk(osc_clk_i), .rst_n(rst_ni), .ready_o(ready_o), .cnt_o(settle_cnt)
  );

  clk_mode_regs #(.NF(NF), .IW(IW)) u_modes (
    .clk(osc_clk_i), .rst_n(rst_ni), .ready(ready_o),
    .wr_en(wr_en_i), .wr_idx(wr_idx_i), .wr_mode(wr_mode_i),
    .shadow_o(mode_shadow), .active_o(mode_active)
  );

  clk_sync2 u_sync_osc (.clk(osc_clk_i), .rst_n(rst_ni), .d(ready_o), .q(en_osc));
  clk_sync2 u_sync_pll (.clk(pll_clk_i), .rst_n(rst_ni), .d(ready_o), .q(en_pll));
  clk_sync2 u_sync_sub (.clk(sub_clk_i), .rst_n(rst_ni), .d(ready_o), .q(en_sub));

  assign gate_osc = osc_clk_i & en_osc;
  assign gate_pll = pll_clk_i & en_pll;
  assign gate_sub = sub_clk_i & en_sub;

  assign main_clk_o   = main_takes_pll(mode_active[1:0]) ? gate_pll : gate_osc;
  assign periph_clk_o = periph_takes_sub(mode_active[3:2]) ? gate_sub : main_clk_o;

  for (genvar k = 0; k < N_AUX; k++) begin : g_aux
    assign aux_clk_o[k] = pick_gated(aux_source(mode_active[(k+2)*2 +: 2]),
                                     gate_osc, gate_pll, gate_sub);
  end
endmodule

// File: rtl/clk_settle_sel_chk.sv
module clk_settle_sel_chk #(
  parameter int NF = 5,
  parameter int LOG2 = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ready,
  input logic            en_osc,
  input logic [LOG2:0]   cnt,
  input logic [NF*2-1:0] shadow,
  input logic [NF*2-1:0] active,
  input logic            main_clk,
  input logic            periph_clk,
  input logic [NF-3:0]   aux_clk
);
  localparam logic [LOG2:0] TC_V = (LOG2+1)'(32'd1 << LOG2);

  // R1
  outputs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!main_clk && !periph_clk && aux_clk == '0));

  // R1
  ready_on_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(cnt) == TC_V - 1'b1);

  // R2
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R2
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cnt == TC_V);

  // R3
  osc_enable_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_osc) |-> $past(ready, 2));

  // R7
  mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(active));

  // R8
  mode_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> active == $past(shadow));
endmodule

bind clk_settle_sel clk_settle_sel_chk #(.NF(NF), .LOG2(SETTLE_LOG2)) u_chk (
  .clk(osc_clk_i), .rst_n(rst_ni), .ready(ready_o), .en_osc(en_osc),
  .cnt(settle_cnt), .shadow(mode_shadow), .active(mode_active),
  .main_clk(main_clk_o), .periph_clk(periph_clk_o), .aux_clk(aux_clk_o)
);

// File: tb/clk_settle_sel_tb.sv
module clk_settle_sel_tb;
  localparam int LOG2 = 5;
  localparam int TC = 1 << LOG2;
  localparam int N_AUX = 3;
  localparam int IW = $clog2(N_AUX + 2);

  logic osc_clk = 1'b0, pll_clk = 1'b0, sub_clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [1:0] wr_mode = '0;
  logic ready, main_clk, periph_clk;
  logic [N_AUX-1:0] aux_clk;

  int checks = 0, bad = 0, edge_cnt = 0;

  always #5  osc_clk = ~osc_clk;
  always #4  pll_clk = ~pll_clk;
  always #20 sub_clk = ~sub_clk;

  always @(posedge osc_clk or negedge rst_n)
    if (!rst_n) edge_cnt <= 0; else edge_cnt <= edge_cnt + 1;

  clk_settle_sel #(.SETTLE_LOG2(LOG2), .N_AUX(N_AUX)) u_dut (
    .osc_clk_i(osc_clk), .pll_clk_i(pll_clk), .sub_clk_i(sub_clk),
    .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_mode_i(wr_mode),
    .ready_o(ready), .main_clk_o(main_clk), .periph_clk_o(periph_clk),
    .aux_clk_o(aux_clk)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // which: 0 main, 1 periph, 2.. aux; src: 0 osc, 1 pll, 2 sub
  function automatic logic out_of(input int which);
    if (which == 0) return main_clk;
    if (which == 1) return periph_clk;
    return aux_clk[which-2];
  endfunction

  function automatic logic src_of(input int src);
    if (src == 1) return pll_clk;
    if (src == 2) return sub_clk;
    return osc_clk;
  endfunction

  task automatic wait_edge(input int n);
    while (edge_cnt < n) begin @(posedge osc_clk); #1; end
    #1;
  endtask

  task automatic write_mode(input int idx, input logic [1:0] m);
    @(negedge osc_clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_mode = m;
    @(negedge osc_clk);
    wr_en = 1'b0;
  endtask

  task automatic check_follow(input string req, input int which, input int src);
    int miss = 0;
    for (int i = 0; i < 24; i++) begin
      @(posedge osc_clk); #2;
      if (out_of(which) !== src_of(src)) miss++;
      @(negedge osc_clk); #3;
      if (out_of(which) !== src_of(src)) miss++;
    end
    checks++;
    if (miss != 0) begin
      bad++;
      $display("FAIL %s output %0d mismatches=%0d expected=0 (source %0d)", req, which, miss, src);
    end
  endtask

  task automatic check_quiet(input string req, input int cycles);
    int hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge osc_clk); #2;
      if (main_clk || periph_clk || aux_clk != '0) hits++;
      @(negedge osc_clk); #3;
      if (main_clk || periph_clk || aux_clk != '0) hits++;
    end
    checks++;
    if (hits != 0) begin
      bad++;
      $display("FAIL %s nonzero samples=%0d expected=0", req, hits);
    end
  endtask

  task automatic t_reset_state;
    #13;
    chk("R9 ready in reset", ready, 1'b0);
    chk("R9 main in reset", main_clk, 1'b0);
    chk("R9 aux in reset", |aux_clk, 1'b0);
    #9 rst_n = 1'b1;
  endtask

  task automatic t_settle_with_held_writes;
    write_mode(2, 2'b01);
    write_mode(3, 2'b10);
    write_mode(4, 2'b11);
    write_mode(5, 2'b01);
    write_mode(0, 2'b10);
    check_quiet("R1 quiet while settling", 14);
    wait_edge(TC - 1);
    chk("R1 ready before count", ready, 1'b0);
    wait_edge(TC);
    chk("R1 ready at count", ready, 1'b1);
    wait_edge(TC + 1);
    chk("R3 main held one edge after ready", main_clk, 1'b0);
    wait_edge(TC + 2);
    chk("R3 main passes osc two edges after ready", main_clk, 1'b1);
    repeat (4) @(posedge osc_clk);
    check_follow("R4 main code 10 uses osc", 0, 0);
    check_follow("R5 periph follows main", 1, 0);
    check_follow("R7 held write aux0 pll", 2, 1);
    check_follow("R6 aux1 sub", 3, 2);
    check_follow("R6 aux2 reserved uses osc", 4, 0);
    chk("R2 ready still set", ready, 1'b1);
  endtask

  task automatic t_live_writes;
    write_mode(0, 2'b01);
    check_follow("R4 main pll", 0, 1);
    check_follow("R5 periph follows main on pll", 1, 1);
    write_mode(1, 2'b10);
    check_follow("R5 periph sub", 1, 2);
    write_mode(2, 2'b00);
    check_follow("R8 aux0 back to osc", 2, 0);
    write_mode(3, 2'b01);
    check_follow("R6 aux1 pll", 3, 1);
  endtask

  task automatic t_mid_reset;
    @(negedge osc_clk); #3;
    rst_n = 1'b0;
    #1;
    chk("R9 ready cleared", ready, 1'b0);
    chk("R9 main cleared", main_clk, 1'b0);
    chk("R9 periph cleared", periph_clk, 1'b0);
    #15 rst_n = 1'b1;
    wait_edge(TC - 1);
    chk("R1 ready before count after reset", ready, 1'b0);
    wait_edge(TC);
    chk("R1 ready at count after reset", ready, 1'b1);
    repeat (6) @(posedge osc_clk);
    check_follow("R9 main mode back to 00", 0, 0);
    check_follow("R9 aux1 mode back to 00", 3, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_settle_with_held_writes();
        t_live_writes();
        t_mid_reset();
      end
      begin
        #500000;
        bad++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule